// File: doc/BRIEF.md
# Mode-Dependent Address Extension Unit

This block turns logical addresses from a processor core into 24-bit physical memory addresses. The core runs in one of two modes. In native mode, addresses are a full 24 bits wide and pass through unchanged. In compatibility mode, programs see a 16-bit address space. That 64KB window is placed in the 24-bit memory by an 8-bit base register, which supplies the upper address byte.

The block holds the mode flag and the base register. The base register can only be written while native mode is active, so code running in compatibility mode cannot move its own window. The mode flag changes only on a strobe whose reason code names one of these events:
- a prefixed call
- a prefixed jump
- a prefixed return
- a prefixed restart
- an interrupt
- a trap

Any other reason code is rejected.

The block also picks the stack pointer: the 24-bit long pointer in native mode, or the 16-bit short pointer relocated by the base in compatibility mode. It reports how many bytes an address or immediate operand takes in the current mode. A rejected base write or a rejected mode change raises a one-cycle error pulse.

Translation is combinational, and there is no data stream, so every pin is a plain level or a strobe with no back-pressure. The mode flag and the base register update on the rising clock edge.

Top module: `addr_ext_unit`

## Requirements
- R1: With `native_mode` = 0, `phys_addr` equals {`base_value`, `logical_addr[15:0]`} in the same cycle, and `logical_addr[23:16]` is ignored.
- R2: With `native_mode` = 1, `phys_addr` equals `logical_addr` in the same cycle, whatever `base_value` holds.
- R3: A `base_wr_en` pulse loads `base_wr_data` into `base_value` at the next edge only if `native_mode` is 1 before that edge. Otherwise `base_value` is unchanged.
- R4: `sp_addr` equals `spl_in` when `native_mode` = 1, and {`base_value`, `sps_in`} when `native_mode` = 0.
- R5: `operand_bytes` is 3 when `native_mode` = 1 and 2 when `native_mode` = 0.
- R6: On a `mode_req_valid` cycle, `native_mode` takes `mode_req_target` at the next edge only if `mode_req_reason` is one of these codes:
  - 1: prefixed call
  - 2: prefixed jump
  - 3: prefixed return
  - 4: prefixed restart
  - 5: interrupt
  - 6: trap

  Codes 0 and 7 leave `native_mode` unchanged. With no request, `native_mode` holds.
- R7: After reset, `native_mode` = 0, `base_value` = 0 and `err_pulse` = 0.
- R8: `err_pulse` is 1 for exactly the one cycle after an edge at which either of these was rejected:
  - a base write
  - a mode request

  It is 0 after edges with only accepted requests or no request.
- R9: When a base write and a mode request arrive in the same cycle, the write is judged against the mode in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req_valid | input | 1 | Mode-change strobe |
| mode_req_target | input | 1 | Requested mode (1 = native) |
| mode_req_reason | input | 3 | Reason code for the mode request |
| base_wr_en | input | 1 | Base-register write strobe |
| base_wr_data | input | 8 | Base-register write value |
| logical_addr | input | 24 | Logical address from the core |
| sps_in | input | 16 | Short stack pointer |
| spl_in | input | 24 | Long stack pointer |
| phys_addr | output | 24 | Translated address |
| sp_addr | output | 24 | Translated stack address |
| native_mode | output | 1 | Current mode flag |
| base_value | output | 8 | Current base register |
| operand_bytes | output | 2 | Address or immediate operand length in bytes |
| err_pulse | output | 1 | One-cycle rejection flag |

## Verification
The assertions take for granted that the strobes are driven to known levels in every cycle after reset. They also assume that `mode_req_reason` is only looked at while `mode_req_valid` is high, so a stale reason code on an idle cycle has no meaning. The stimulus drives and releases every input one time unit after a rising edge, and returns the strobes to 0 after each request.

The sweep covers:
- every base value, each with several addresses in both modes
- every reason code from both starting modes, toward both targets
- the cases where a base write and a mode request arrive in the same cycle

// File: rtl/aeu_pkg.sv
package aeu_pkg;
  localparam int REASON_W = 3;

  typedef enum logic [REASON_W-1:0] {
    RSN_NONE   = 3'd0,
    RSN_CALL   = 3'd1,
    RSN_JUMP   = 3'd2,
    RSN_RETURN = 3'd3,
    RSN_RESTRT = 3'd4,
    RSN_INTR   = 3'd5,
    RSN_TRAP   = 3'd6,
    RSN_RSVD   = 3'd7
  } reason_e;

  function automatic logic reason_allows_switch(input logic [REASON_W-1:0] r);
    case (reason_e'(r))
      RSN_CALL, RSN_JUMP, RSN_RETURN, RSN_RESTRT, RSN_INTR, RSN_TRAP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/aeu_mode_ctrl.sv
module aeu_mode_ctrl
  import aeu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_target,
  input  logic [REASON_W-1:0] req_reason,
  output logic                native_q,
  output logic                reject
);
  logic legal;

  always_comb begin
    legal  = reason_allows_switch(req_reason);
    reject = req_valid && !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 native_q <= 1'b0;
    else if (req_valid && legal) native_q <= req_target;
  end
endmodule

// File: rtl/aeu_base_reg.sv
module aeu_base_reg #(
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BASE_W-1:0] wr_data,
  input  logic              native_now,
  output logic [BASE_W-1:0] base_q,
  output logic              reject
);
  logic accept;

  always_comb begin
    accept = wr_en && native_now;
    reject = wr_en && !native_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= '0;
    else if (accept) base_q <= wr_data;
  end
endmodule

// File: rtl/aeu_xlate.sv
module aeu_xlate #(
  parameter int BASE_W = 8,
  parameter int LOG_W  = 16
) (
  input  logic                    native,
  input  logic [BASE_W-1:0]       base,
  input  logic [BASE_W+LOG_W-1:0] addr_in,
  output logic [BASE_W+LOG_W-1:0] addr_out
);
  always_comb begin
    if (native) addr_out = addr_in;
    else        addr_out = {base, addr_in[LOG_W-1:0]};
  end
endmodule

// File: rtl/aeu_err.sv
module aeu_err #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] rej,
  output logic             err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= |rej;
  end
endmodule

// File: rtl/addr_ext_unit.sv
module addr_ext_unit
  import aeu_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int LOG_W  = 16,
  localparam int FULL_W = BASE_W + LOG_W,
  localparam int LONG_BYTES  = FULL_W / 8,
  localparam int LEN_W = $clog2(LONG_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_req_valid,
  input  logic                mode_req_target,
  input  logic [REASON_W-1:0] mode_req_reason,
  input  logic                base_wr_en,
  input  logic [BASE_W-1:0]   base_wr_data,
  input  logic [FULL_W-1:0]   logical_addr,
  input  logic [LOG_W-1:0]    sps_in,
  input  logic [FULL_W-1:0]   spl_in,
  output logic [FULL_W-1:0]   phys_addr,
  output logic [FULL_W-1:0]   sp_addr,
  output logic                native_mode,
  output logic [BASE_W-1:0]   base_value,
  output logic [LEN_W-1:0]    operand_bytes,
  output logic                err_pulse
);
  localparam int SHORT_BYTES = LOG_W / 8;
  localparam int N_PATH = 2;

  logic              mode_rej, base_rej;
  logic [FULL_W-1:0] path_in  [N_PATH];
  logic [FULL_W-1:0] path_out [N_PATH];

  aeu_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n),
    .req_valid(mode_req_valid), .req_target(mode_req_target),
    .req_reason(mode_req_reason),
    .native_q(native_mode), .reject(mode_rej)
  );

  aeu_base_reg #(.BASE_W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n),
    .wr_en(base_wr_en), .wr_data(base_wr_data),
    .native_now(native_mode),
    .base_q(base_value), .reject(base_rej)
  );

  always_comb begin
    path_in[0] = logical_addr;
    path_in[1] = native_mode ? spl_in : {{BASE_W{1'b0}}, sps_in};
  end

  for (genvar g = 0; g < N_PATH; g++) begin : g_path
    aeu_xlate #(.BASE_W(BASE_W), .LOG_W(LOG_W)) u_xl (
      .native(native_mode), .base(base_value),
      .addr_in(path_in[g]), .addr_out(path_out[g])
    );
  end

  always_comb begin
    phys_addr     = path_out[0];
    sp_addr       = path_out[1];
    operand_bytes = native_mode ? LEN_W'(LONG_BYTES) : LEN_W'(SHORT_BYTES);
  end

  aeu_err #(.N_SRC(2)) u_err (
    .clk(clk), .rst_n(rst_n),
    .rej({mode_rej, base_rej}),
    .err_q(err_pulse)
  );
endmodule

// File: rtl/aeu_checker.sv
module aeu_checker #(
  parameter int BASE_W = 8,
  parameter int LOG_W  = 16,
  parameter int FULL_W = 24,
  parameter int LEN_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_req_valid,
  input logic              mode_req_target,
  input logic [2:0]        mode_req_reason,
  input logic              base_wr_en,
  input logic [BASE_W-1:0] base_wr_data,
  input logic [FULL_W-1:0] logical_addr,
  input logic [LOG_W-1:0]  sps_in,
  input logic [FULL_W-1:0] spl_in,
  input logic [FULL_W-1:0] phys_addr,
  input logic [FULL_W-1:0] sp_addr,
  input logic              native_mode,
  input logic [BASE_W-1:0] base_value,
  input logic [LEN_W-1:0]  operand_bytes,
  input logic              err_pulse
);
  logic legal_rsn;
  assign legal_rsn = (mode_req_reason != 3'd0) && (mode_req_reason != 3'd7);

  p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !native_mode |-> (phys_addr[FULL_W-1:LOG_W] == base_value &&
                      phys_addr[LOG_W-1:0] == logical_addr[LOG_W-1:0]));

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    native_mode |-> phys_addr == logical_addr);

  p_base_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!native_mode || !base_wr_en) |=> $stable(base_value));

  p_stack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    native_mode |-> sp_addr == spl_in);

  p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    operand_bytes == (native_mode ? LEN_W'(3) : LEN_W'(2)));

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_req_valid && legal_rsn) |=> $stable(native_mode));

  p_err_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_req_valid && !legal_rsn) || (base_wr_en && !native_mode)) |=> err_pulse);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_req_valid && !base_wr_en) |=> !err_pulse);
endmodule

bind addr_ext_unit aeu_checker #(
  .BASE_W(BASE_W), .LOG_W(LOG_W), .FULL_W(FULL_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mode_req_valid(mode_req_valid), .mode_req_target(mode_req_target),
  .mode_req_reason(mode_req_reason),
  .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
  .logical_addr(logical_addr), .sps_in(sps_in), .spl_in(spl_in),
  .phys_addr(phys_addr), .sp_addr(sp_addr), .native_mode(native_mode),
  .base_value(base_value), .operand_bytes(operand_bytes), .err_pulse(err_pulse)
);

// File: tb/addr_ext_unit_tb.sv
module addr_ext_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_req_valid = 1'b0, mode_req_target = 1'b0;
  logic [2:0]  mode_req_reason = 3'd0;
  logic        base_wr_en = 1'b0;
  logic [7:0]  base_wr_data = 8'd0;
  logic [23:0] logical_addr = 24'd0;
  logic [15:0] sps_in = 16'd0;
  logic [23:0] spl_in = 24'd0;
  logic [23:0] phys_addr, sp_addr;
  logic        native_mode, err_pulse;
  logic [7:0]  base_value;
  logic [1:0]  operand_bytes;

  int n_chk = 0, n_bad = 0;
  logic       m_native = 1'b0;
  logic [7:0] m_base = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_ext_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .mode_req_valid(mode_req_valid), .mode_req_target(mode_req_target),
    .mode_req_reason(mode_req_reason),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .logical_addr(logical_addr), .sps_in(sps_in), .spl_in(spl_in),
    .phys_addr(phys_addr), .sp_addr(sp_addr), .native_mode(native_mode),
    .base_value(base_value), .operand_bytes(operand_bytes), .err_pulse(err_pulse)
  );

  task automatic ck(input logic ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One request cycle; returns with registered results visible.
  task automatic step(input logic mv, input logic mt, input logic [2:0] mr,
                      input logic bw, input logic [7:0] bd, output logic exp_err);
    logic legal;
    legal = (mr != 3'd0) && (mr != 3'd7);
    exp_err = (mv && !legal) || (bw && !m_native);
    mode_req_valid = mv; mode_req_target = mt; mode_req_reason = mr;
    base_wr_en = bw; base_wr_data = bd;
    @(posedge clk); #1;
    if (bw && m_native) m_base = bd;          // R9: old mode decides
    if (mv && legal) m_native = mt;
    mode_req_valid = 1'b0; base_wr_en = 1'b0; mode_req_reason = 3'd0;
  endtask

  task automatic check_comb(input logic [23:0] la, input logic [15:0] sps, input logic [23:0] spl);
    logic [23:0] e;
    logical_addr = la; sps_in = sps; spl_in = spl; #1;
    e = m_native ? la : {m_base, la[15:0]};
    ck(phys_addr == e, m_native ? "R2 passthrough" : "R1 window", phys_addr, e);
    e = m_native ? spl : {m_base, sps};
    ck(sp_addr == e, "R4 stack select", sp_addr, e);
    ck(operand_bytes == (m_native ? 2'd3 : 2'd2), "R5 operand bytes",
       24'(operand_bytes), m_native ? 24'd3 : 24'd2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ee;
    repeat (3) @(posedge clk);
    #1;
    ck(native_mode == 1'b0, "R7 reset mode", 24'(native_mode), 24'd0);
    ck(base_value == 8'd0, "R7 reset base", 24'(base_value), 24'd0);
    ck(err_pulse == 1'b0, "R7 reset err", 24'(err_pulse), 24'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_comb(24'hAB1234, 16'h0FF0, 24'h123456);

    // R3: write attempt in compatibility mode is dropped, error pulses once.
    step(1'b0, 1'b0, 3'd0, 1'b1, 8'h5A, ee);
    ck(base_value == m_base, "R3 locked write", 24'(base_value), 24'(m_base));
    ck(err_pulse == ee, "R8 base reject", 24'(err_pulse), 24'(ee));
    @(posedge clk); #1;
    ck(err_pulse == 1'b0, "R8 one cycle", 24'(err_pulse), 24'd0);

    // Sweep every base value.
    for (int b = 0; b < 256; b++) begin
      step(1'b1, 1'b1, 3'd5, 1'b0, 8'd0, ee);                     // enter native
      ck(native_mode == 1'b1, "R6 enter native", 24'(native_mode), 24'd1);
      step(1'b0, 1'b0, 3'd0, 1'b1, 8'(b), ee);
      ck(base_value == 8'(b), "R3 native write", 24'(base_value), 24'(b));
      ck(err_pulse == 1'b0, "R8 accepted write", 24'(err_pulse), 24'd0);
      check_comb(24'((b * 24'h010101) ^ 24'hC3A5F0), 16'(b * 257), 24'(b * 24'h00F00F));
      step(1'b1, 1'b0, 3'(1 + (b % 6)), 1'b0, 8'd0, ee);          // back to compat
      ck(native_mode == 1'b0, "R6 leave native", 24'(native_mode), 24'd0);
      for (int k = 0; k < 4; k++)
        check_comb(24'(k * 24'h3F5A1 + b * 24'h10203), 16'(k * 16'h4321 + b), 24'hFFFFFF);
    end

    // Sweep all reason codes from both starting modes toward both targets.
    for (int s = 0; s < 2; s++)
      for (int t = 0; t < 2; t++)
        for (int r = 0; r < 8; r++) begin
          step(1'b1, 1'(s), 3'd6, 1'b0, 8'd0, ee);
          step(1'b1, 1'(t), 3'(r), 1'b0, 8'd0, ee);
          ck(native_mode == m_native, "R6 reason gate", 24'(native_mode), 24'(m_native));
          ck(err_pulse == ee, "R8 mode reject", 24'(err_pulse), 24'(ee));
          @(posedge clk); #1;
          ck(err_pulse == 1'b0, "R8 pulse width", 24'(err_pulse), 24'd0);
        end

    // R9: simultaneous write and mode change, judged by the old mode.
    step(1'b1, 1'b1, 3'd2, 1'b0, 8'd0, ee);
    step(1'b1, 1'b0, 3'd3, 1'b1, 8'h77, ee);
    ck(base_value == 8'h77, "R9 write before leaving", 24'(base_value), 24'h77);
    ck(native_mode == 1'b0, "R9 mode left", 24'(native_mode), 24'd0);
    step(1'b1, 1'b1, 3'd4, 1'b1, 8'h11, ee);
    ck(base_value == 8'h77, "R9 write before entering", 24'(base_value), 24'h77);
    ck(native_mode == 1'b1, "R9 mode entered", 24'(native_mode), 24'd1);
    ck(err_pulse == 1'b1, "R9 error flagged", 24'(err_pulse), 24'd1);
    check_comb(24'h89ABCD, 16'h2468, 24'hFEDCBA);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule